// File: doc/BRIEF.md
# CD Sector Decoder Status Emulator

This block supplies the decoder-status half of an emulated CD controller. A processor that fetches data sectors streamed in by a host uses it to learn where the disc is and whether a fresh sector is ready. No real disc bits are decoded. The header registers report a position counter, and the status registers return fixed values that always mean "good sector".

On a play request the block loads a minutes/seconds/frames position equal to the requested one less three frames. The current position then reads back in BCD through three header registers. Each time the host reports a fully delivered sector, the block latches a decoder interrupt, provided the enable bit is set. The active-low interrupt line stays low until the processor reads the interrupt status register. Once the DMA side has moved a 2048-byte sector, a one-cycle step pulse advances the position by one frame.

Top module: `cdd_status_emu`

## Requirements
- R1: After reset the position is 00:00:00, the control register reads 0x00 and `dec_irq_n` is high.
- R2: A `play_start` pulse loads the requested BCD position minus 3 frames, borrowing across frames (0..74) and seconds (0..59). A request below 00:00:03 loads 00:00:00.
- R3: Register addresses 0x0, 0x1 and 0x2 read the current minutes, seconds and frames as two-digit BCD (tens in bits 7:4).
- R4: A `pos_inc` pulse adds one frame. Frame 74 wraps to 0 and carries into seconds, second 59 wraps to 0 and carries into minutes, and minute 99 wraps to 00.
- R5: A `sector_done` pulse while the enable bit is set latches a pending interrupt, and `dec_irq_n` is low from the next cycle on.
- R6: A `sector_done` pulse while the enable bit is clear is dropped. Setting the enable later does not lower `dec_irq_n`, and the pending bit reads 0.
- R7: Address 0xB reads the pending flag in bit 0, and a read of it clears the flag. If a `sector_done` with enable set lands in the same cycle, the flag stays set.
- R8: Address 0x4 always reads 0x04 and address 0x5 always reads 0x00, which together form a data pointer of 0x0004.
- R9: Address 0x8 reads 0x80 (CRC-good bit 7 set, all error bits clear), and address 0x9 reads 0x00.
- R10: Writing address 0xF stores a control byte that reads back there. Bit 0 is the interrupt enable. Clearing it raises `dec_irq_n` without discarding a pending flag, and setting it again lowers the line.
- R11: When `play_start` and `pos_inc` arrive in the same cycle, the load wins. Any unmapped address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_start | input | 1 | Load position from request |
| req_min | input | 8 | Requested minutes, BCD |
| req_sec | input | 8 | Requested seconds, BCD |
| req_frm | input | 8 | Requested frames, BCD |
| pos_inc | input | 1 | Advance position one frame |
| sector_done | input | 1 | Host finished delivering a sector |
| reg_addr | input | 4 | Register address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, same cycle |
| dec_irq_n | output | 1 | Decoder interrupt, active low |

## Verification
On every cycle the assertions check the interrupt line. It falls only after an enabled sector-done event or a re-enable, it is low after an enabled event, and it rises after a clearing read or after the enable is cleared. They also check that each step moves the frame field by exactly one or wraps it, that the position fields stay within their ranges, and that the pointer register reads constant. Only the bench scenarios can show the load arithmetic with borrows and clamping, the carry chain up to the minute wrap, dropped events that stay dropped after re-enabling, and the same-cycle races between set and clear and between load and step.

// File: rtl/cdd_pkg.sv
package cdd_pkg;

    localparam int FLD_W = 7;

    typedef logic [FLD_W-1:0] fld_t;

    typedef struct packed {
        fld_t mins;
        fld_t secs;
        fld_t frms;
    } pos_t;

    typedef struct packed {
        pos_t       pos;
        logic       pend;
        logic [7:0] ctrl;
    } state_t;

    localparam logic [3:0] ADDR_HDR_MIN = 4'h0;
    localparam logic [3:0] ADDR_HDR_SEC = 4'h1;
    localparam logic [3:0] ADDR_HDR_FRM = 4'h2;
    localparam logic [3:0] ADDR_PTR_LO  = 4'h4;
    localparam logic [3:0] ADDR_PTR_HI  = 4'h5;
    localparam logic [3:0] ADDR_STS0    = 4'h8;
    localparam logic [3:0] ADDR_STS1    = 4'h9;
    localparam logic [3:0] ADDR_STS3    = 4'hB;
    localparam logic [3:0] ADDR_CTRL    = 4'hF;

    localparam logic [7:0] STS0_GOOD = 8'h80;
    localparam logic [7:0] STS1_GOOD = 8'h00;

    function automatic fld_t bcd_to_bin(input logic [7:0] b);
        return fld_t'(b[7:4]) * fld_t'(10) + fld_t'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input fld_t v);
        return (8'(v / fld_t'(10)) << 4) | 8'(v % fld_t'(10));
    endfunction

endpackage

// File: rtl/cdd_pos_next.sv
module cdd_pos_next
    import cdd_pkg::*;
#(
    parameter int FPS  = 75,
    parameter int SPM  = 60,
    parameter int MLIM = 100,
    parameter int LEAD = 3
) (
    input  pos_t       cur,
    input  logic       load,
    input  logic [7:0] req_min,
    input  logic [7:0] req_sec,
    input  logic [7:0] req_frm,
    input  logic       step,
    output pos_t       nxt
);

    localparam fld_t FRM_LAST = fld_t'(FPS - 1);
    localparam fld_t SEC_LAST = fld_t'(SPM - 1);
    localparam fld_t MIN_LAST = fld_t'(MLIM - 1);
    localparam fld_t LEAD_V   = fld_t'(LEAD);
    localparam fld_t WRAP_ADD = fld_t'(FPS - LEAD);

    fld_t rq_m, rq_s, rq_f;
    pos_t start_p;
    pos_t step_p;
    logic brw_f, brw_s;

    assign rq_m = bcd_to_bin(req_min);
    assign rq_s = bcd_to_bin(req_sec);
    assign rq_f = bcd_to_bin(req_frm);

    // start position: request minus lead-in, borrowing upward
    always_comb begin
        start_p.mins = rq_m;
        start_p.secs = rq_s;
        brw_s        = 1'b0;
        if (rq_f >= LEAD_V) begin
            start_p.frms = rq_f - LEAD_V;
            brw_f        = 1'b0;
        end else begin
            start_p.frms = rq_f + WRAP_ADD;
            brw_f        = 1'b1;
        end
        if (brw_f) begin
            if (rq_s != '0) begin
                start_p.secs = rq_s - fld_t'(1);
            end else begin
                start_p.secs = SEC_LAST;
                brw_s        = 1'b1;
            end
        end
        if (brw_s) begin
            if (rq_m != '0) begin
                start_p.mins = rq_m - fld_t'(1);
            end else begin
                start_p = '0;
            end
        end
    end

    // one-frame advance with carry chain
    always_comb begin
        step_p = cur;
        if (cur.frms == FRM_LAST) begin
            step_p.frms = '0;
            if (cur.secs == SEC_LAST) begin
                step_p.secs = '0;
                step_p.mins = (cur.mins == MIN_LAST) ? '0 : cur.mins + fld_t'(1);
            end else begin
                step_p.secs = cur.secs + fld_t'(1);
            end
        end else begin
            step_p.frms = cur.frms + fld_t'(1);
        end
    end

    always_comb begin
        if (load) begin
            nxt = start_p;
        end else if (step) begin
            nxt = step_p;
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/cdd_irq_next.sv
module cdd_irq_next (
    input  logic       pend,
    input  logic [7:0] ctrl,
    input  logic       done,
    input  logic       clr,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_data,
    output logic       pend_nxt,
    output logic [7:0] ctrl_nxt
);

    logic en;
    assign en = ctrl[0];

    always_comb begin
        ctrl_nxt = ctl_wr ? ctl_data : ctrl;
        if (done && en) begin
            pend_nxt = 1'b1;
        end else if (clr) begin
            pend_nxt = 1'b0;
        end else begin
            pend_nxt = pend;
        end
    end

endmodule

// File: rtl/cdd_reg_read.sv
module cdd_reg_read
    import cdd_pkg::*;
#(
    parameter logic [15:0] PTR_VALUE = 16'h0004
) (
    input  logic [3:0] addr,
    input  pos_t       pos,
    input  logic       pend,
    input  logic [7:0] ctrl,
    output logic [7:0] rdata
);

    always_comb begin
        unique case (addr)
            ADDR_HDR_MIN: rdata = bin_to_bcd(pos.mins);
            ADDR_HDR_SEC: rdata = bin_to_bcd(pos.secs);
            ADDR_HDR_FRM: rdata = bin_to_bcd(pos.frms);
            ADDR_PTR_LO:  rdata = PTR_VALUE[7:0];
            ADDR_PTR_HI:  rdata = PTR_VALUE[15:8];
            ADDR_STS0:    rdata = STS0_GOOD;
            ADDR_STS1:    rdata = STS1_GOOD;
            ADDR_STS3:    rdata = {7'b0, pend};
            ADDR_CTRL:    rdata = ctrl;
            default:      rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/cdd_status_emu.sv
module cdd_status_emu
    import cdd_pkg::*;
#(
    parameter int          FRAMES_PER_SEC = 75,
    parameter int          SECS_PER_MIN   = 60,
    parameter int          MIN_LIMIT      = 100,
    parameter int          LEAD_FRAMES    = 3,
    parameter logic [15:0] PTR_VALUE      = 16'h0004
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       play_start,
    input  logic [7:0] req_min,
    input  logic [7:0] req_sec,
    input  logic [7:0] req_frm,
    input  logic       pos_inc,
    input  logic       sector_done,
    input  logic [3:0] reg_addr,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       dec_irq_n
);

    state_t st_d, st_q;

    pos_t       pos_q, pos_n;
    logic       pend_q, pend_n;
    logic [7:0] ctrl_q, ctrl_n;
    fld_t       frm_q, sec_q, min_q;
    logic       en_q;
    logic       sts3_rd, ctrl_wr;

    assign pos_q   = st_q.pos;
    assign pend_q  = st_q.pend;
    assign ctrl_q  = st_q.ctrl;
    assign frm_q   = pos_q.frms;
    assign sec_q   = pos_q.secs;
    assign min_q   = pos_q.mins;
    assign en_q    = ctrl_q[0];
    assign sts3_rd = reg_rd && (reg_addr == ADDR_STS3);
    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    cdd_pos_next #(
        .FPS  (FRAMES_PER_SEC),
        .SPM  (SECS_PER_MIN),
        .MLIM (MIN_LIMIT),
        .LEAD (LEAD_FRAMES)
    ) pos_next_i (
        .cur     (pos_q),
        .load    (play_start),
        .req_min (req_min),
        .req_sec (req_sec),
        .req_frm (req_frm),
        .step    (pos_inc),
        .nxt     (pos_n)
    );

    cdd_irq_next irq_next_i (
        .pend     (pend_q),
        .ctrl     (ctrl_q),
        .done     (sector_done),
        .clr      (sts3_rd),
        .ctl_wr   (ctrl_wr),
        .ctl_data (reg_wdata),
        .pend_nxt (pend_n),
        .ctrl_nxt (ctrl_n)
    );

    cdd_reg_read #(
        .PTR_VALUE (PTR_VALUE)
    ) reg_read_i (
        .addr  (reg_addr),
        .pos   (pos_q),
        .pend  (pend_q),
        .ctrl  (ctrl_q),
        .rdata (reg_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pos  = pos_n;
        st_d.pend = pend_n;
        st_d.ctrl = ctrl_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_irq_n = ~(pend_q & en_q);

endmodule

// File: rtl/cdd_status_chk.sv
module cdd_status_chk
    import cdd_pkg::*;
#(
    parameter int          FPS       = 75,
    parameter int          SPM       = 60,
    parameter int          MLIM      = 100,
    parameter logic [15:0] PTR_VALUE = 16'h0004
) (
    input logic       clk,
    input logic       rst_n,
    input logic       play_start,
    input logic       pos_inc,
    input logic       sector_done,
    input logic [3:0] reg_addr,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       dec_irq_n,
    input logic       en_q,
    input fld_t       frm_q,
    input fld_t       sec_q,
    input fld_t       min_q
);

    localparam fld_t FRM_LAST = fld_t'(FPS - 1);
    localparam fld_t SEC_LIM  = fld_t'(SPM);
    localparam fld_t MIN_LIM  = fld_t'(MLIM);

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_done && en_q && !(reg_wr && reg_addr == ADDR_CTRL && !reg_wdata[0]))
        |=> !dec_irq_n);

    // R7
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_STS3 && !sector_done) |=> dec_irq_n);

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dec_irq_n) |->
            ($past(sector_done && en_q) || $past(reg_wr && reg_addr == ADDR_CTRL && reg_wdata[0])));

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL && !reg_wdata[0]) |=> dec_irq_n);

    // R4
    frm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_inc && !play_start) |=>
            ((frm_q == fld_t'($past(frm_q) + fld_t'(1))) ||
             (frm_q == '0 && $past(frm_q) == FRM_LAST)));

    // R4
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q <= FRM_LAST) && (sec_q < SEC_LIM) && (min_q < MIN_LIM));

    // R8
    ptr_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_PTR_LO) |-> (reg_rdata == PTR_VALUE[7:0]));

endmodule

bind cdd_status_emu cdd_status_chk #(
    .FPS       (FRAMES_PER_SEC),
    .SPM       (SECS_PER_MIN),
    .MLIM      (MIN_LIMIT),
    .PTR_VALUE (PTR_VALUE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .play_start  (play_start),
    .pos_inc     (pos_inc),
    .sector_done (sector_done),
    .reg_addr    (reg_addr),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .dec_irq_n   (dec_irq_n),
    .en_q        (en_q),
    .frm_q       (frm_q),
    .sec_q       (sec_q),
    .min_q       (min_q)
);

// File: tb/cdd_status_emu_tb_top.sv
module cdd_status_emu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       play_start = 1'b0;
    logic [7:0] req_min = '0, req_sec = '0, req_frm = '0;
    logic       pos_inc = 1'b0;
    logic       sector_done = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       dec_irq_n;

    int checks = 0;
    int errors = 0;
    int model_total = 0;
    bit finished = 0;

    localparam int FULL_SPAN = 100 * 60 * 75;

    always #2 clk = ~clk;

    cdd_status_emu dut_i (
        .clk (clk), .rst_n (rst_n), .play_start (play_start),
        .req_min (req_min), .req_sec (req_sec), .req_frm (req_frm),
        .pos_inc (pos_inc), .sector_done (sector_done),
        .reg_addr (reg_addr), .reg_rd (reg_rd), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .dec_irq_n (dec_irq_n)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic check_pos(input string req);
        logic [7:0] d;
        int m, s, f;
        m = model_total / 4500;
        s = (model_total / 75) % 60;
        f = model_total % 75;
        peek(4'h0, d); check(req, d, to_bcd(m));
        peek(4'h1, d); check(req, d, to_bcd(s));
        peek(4'h2, d); check(req, d, to_bcd(f));
    endtask

    task automatic play(input int m, input int s, input int f);
        @(negedge clk);
        req_min = to_bcd(m); req_sec = to_bcd(s); req_frm = to_bcd(f);
        play_start = 1'b1;
        @(negedge clk);
        play_start = 1'b0;
        model_total = (m * 60 + s) * 75 + f - 3;
        if (model_total < 0) model_total = 0;
    endtask

    task automatic step_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pos_inc = 1'b1;
            @(negedge clk);
            pos_inc = 1'b0;
            model_total = (model_total + 1) % FULL_SPAN;
        end
    endtask

    task automatic pulse_done();
        @(negedge clk);
        sector_done = 1'b1;
        @(negedge clk);
        sector_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        #1 check("R1 irq after reset", dec_irq_n, 1);
        model_total = 0;
        check_pos("R1 position after reset");
        peek(4'hF, d); check("R1 ctrl after reset", d, 8'h00);
    endtask

    task automatic t_fixed();
        logic [7:0] d;
        peek(4'h4, d); check("R8 pointer low", d, 8'h04);
        peek(4'h5, d); check("R8 pointer high", d, 8'h00);
        peek(4'h8, d); check("R9 status0", d, 8'h80);
        peek(4'h9, d); check("R9 status1", d, 8'h00);
        peek(4'h3, d); check("R11 unmapped 3", d, 8'h00);
        peek(4'hC, d); check("R11 unmapped C", d, 8'h00);
    endtask

    task automatic t_play();
        play(12, 34, 56); check_pos("R2 R3 plain load");
        play(0, 2, 2);    check_pos("R2 frame borrow");
        play(1, 0, 1);    check_pos("R2 second borrow");
        play(0, 0, 2);    check_pos("R2 clamp low");
        play(0, 0, 3);    check_pos("R2 exact lead");
    endtask

    task automatic t_step();
        play(0, 2, 2); step_n(1); check_pos("R4 frame wrap");
        play(1, 0, 1); step_n(2); check_pos("R4 second wrap");
        play(99, 59, 74); step_n(4); check_pos("R4 minute wrap");
        step_n(3); check_pos("R4 plain steps");
    endtask

    task automatic t_load_race();
        @(negedge clk);
        req_min = to_bcd(5); req_sec = to_bcd(6); req_frm = to_bcd(7);
        play_start = 1'b1; pos_inc = 1'b1;
        @(negedge clk);
        play_start = 1'b0; pos_inc = 1'b0;
        model_total = (5 * 60 + 6) * 75 + 7 - 3;
        check_pos("R11 load beats step");
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(4'hF, 8'h01);
        peek(4'hF, d); check("R10 ctrl readback", d, 8'h01);
        check("R5 idle irq", dec_irq_n, 1);
        pulse_done();
        #1 check("R5 irq after done", dec_irq_n, 0);
        rd(4'hB, d);
        check("R7 pending bit", d, 8'h01);
        #1 check("R7 irq cleared", dec_irq_n, 1);
        peek(4'hB, d); check("R7 pending cleared", d, 8'h00);
    endtask

    task automatic t_drop();
        logic [7:0] d;
        wr(4'hF, 8'h00);
        pulse_done();
        #1 check("R6 dropped irq", dec_irq_n, 1);
        wr(4'hF, 8'h01);
        #1 check("R6 still high after enable", dec_irq_n, 1);
        peek(4'hB, d); check("R6 pending empty", d, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        pulse_done();
        #1 check("R10 irq low", dec_irq_n, 0);
        wr(4'hF, 8'h00);
        #1 check("R10 masked", dec_irq_n, 1);
        peek(4'hB, d); check("R10 pending kept", d, 8'h01);
        wr(4'hF, 8'h01);
        #1 check("R10 unmasked", dec_irq_n, 0);
        rd(4'hB, d);
        #1 check("R10 cleared", dec_irq_n, 1);
    endtask

    task automatic t_clr_race();
        logic [7:0] d;
        @(negedge clk);
        sector_done = 1'b1;
        reg_addr = 4'hB;
        reg_rd = 1'b1;
        @(negedge clk);
        sector_done = 1'b0;
        reg_rd = 1'b0;
        #1 check("R7 set beats clear", dec_irq_n, 0);
        rd(4'hB, d);
        #1 check("R7 cleared after race", dec_irq_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_play();
        t_step();
        t_load_race();
        t_irq();
        t_drop();
        t_mask();
        t_clr_race();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule